// File: doc/BRIEF.md
# Pipeline Interlock and Fetch-Hold Controller

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode with register read, execute with address generation, memory, writeback) may advance. It looks at the register sources named by the instruction in decode and at the destinations that the execute, memory and writeback stages are about to write. If any of those later stages will write a register that decode needs, the pipeline front end freezes and a bubble enters execute. There is no forwarding. Only true read-after-write matches cause a stall. Write-after-read and write-after-write cases are left alone, because every register write happens in one stage and in program order.

The same block holds fetch around control-flow instructions, since there is no prediction. A direct jump or call computes its PC-plus-offset target in decode. Fetch is redirected at once and the one sequentially fetched instruction is squashed. A conditional branch, a return or an indirect jump needs execute to produce its target. Fetch is held and the fetched slot squashed until execute reports the target, and fetch resumes from that target in the next cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When a decode source whose use flag is set equals the destination of the execute stage (lat_dst index 0) or the memory stage (index 1), and that stage's write enable is set and the destination is not register 0, the outputs are hold_fetch=1, hold_dec=1, bubble_ex=1, squash_dec=0, redirect=0 in the same cycle. Source i sits at dec_src[AW*i +: AW] and stage j at lat_dst[AW*j +: AW].
- R2: With the default WB_SPLIT=0, a match of the same kind against the writeback stage (index 2) also gives the stall outputs of R1.
- R3: A match counts for nothing when the stage's write enable is low, when the destination is register 0, or when the source's use flag is low. With no other cause all five outputs are 0.
- R4: dec_cf encodes the decode instruction's class: 0 none, 1 conditional branch, 2 direct jump or call, 3 return or indirect jump.
- R5: With no stall and dec_cf=2, redirect=1 and squash_dec=1 in the same cycle, with hold_fetch, hold_dec and bubble_ex at 0.
- R6: With no stall and dec_cf equal to 1 or 3, hold_fetch=1 and squash_dec=1 (others 0), and the unit enters a waiting state from the next cycle.
- R7: While waiting, each cycle with ex_resolved=0 gives hold_fetch=1 and squash_dec=1. The cycle with ex_resolved=1 gives redirect=1 and squash_dec=1 with hold_fetch=0, and waiting ends after that cycle.
- R8: A data stall takes priority over a control-flow instruction in decode: the outputs are those of R1, and no redirect and no waiting state follow.
- R9: During and right after reset the unit is not waiting, and with quiet inputs all outputs are 0.
- R10: While waiting, the decode fields and the stage destinations are ignored. The outputs follow R7 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_src | input | NSRC*AW | Source register fields of the decode instruction |
| dec_src_use | input | NSRC | Per-source use flags |
| dec_cf | input | 2 | Control-flow class of the decode instruction |
| lat_dst | input | 3*AW | Destinations of execute, memory and writeback |
| lat_wen | input | 3 | Write enables of execute, memory and writeback |
| ex_resolved | input | 1 | Execute has produced the waiting branch's target |
| hold_fetch | output | 1 | Keep the PC unchanged |
| hold_dec | output | 1 | Keep the fetch/decode register unchanged |
| bubble_ex | output | 1 | Load a bubble with all writes cleared into decode/execute |
| squash_dec | output | 1 | Load a bubble into fetch/decode instead of the fetched word |
| redirect | output | 1 | PC loads the resolved target |

## Verification
The assertions assume that ex_resolved is raised only while a branch from decode waits in execute. They also assume that execute resolves such a branch in one cycle or reports it late, but never early. The stimulus keeps this assumption by raising ex_resolved only when its own model is in the waiting state. It drives arbitrary decode and stage values during the wait so that the ignore rule is exercised. Directed sequences cover each stage match, each masking cause and each branch class. A pseudo-random phase then draws registers from a small set so that matches and branch collisions happen often.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        CF_NONE = 2'd0,
        CF_COND = 2'd1,
        CF_JUMP = 2'd2,
        CF_REG  = 2'd3
    } cf_class_e;

    typedef struct packed {
        logic br_wait;
    } seq_state_t;

    typedef struct packed {
        logic hold_fetch;
        logic hold_dec;
        logic bubble_ex;
        logic squash_dec;
        logic redirect;
    } ctl_out_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC*AW-1:0] srcs,
    input  logic [NSRC-1:0]    src_use,
    input  logic [AW-1:0]      dst,
    input  logic               wen,
    output logic               hit
);
    logic [NSRC-1:0] per_src;
    logic            dst_live;

    assign dst_live = wen && (dst != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign per_src[i] = dst_live && src_use[i] && (srcs[AW*i +: AW] == dst);
    end

    assign hit = |per_src;
endmodule

// File: rtl/hz_cf_seq.sv
module hz_cf_seq
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      data_hit,
    input  cf_class_e dec_cf,
    input  logic      ex_resolved,
    output ctl_out_t  ctl
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ctl  = '0;
        if (st_q.br_wait) begin
            ctl.squash_dec = 1'b1;
            if (ex_resolved) begin
                ctl.redirect  = 1'b1;
                st_d.br_wait  = 1'b0;
            end else begin
                ctl.hold_fetch = 1'b1;
            end
        end else if (data_hit) begin
            ctl.hold_fetch = 1'b1;
            ctl.hold_dec   = 1'b1;
            ctl.bubble_ex  = 1'b1;
        end else begin
            case (dec_cf)
                CF_JUMP: begin
                    ctl.redirect   = 1'b1;
                    ctl.squash_dec = 1'b1;
                end
                CF_COND, CF_REG: begin
                    ctl.hold_fetch = 1'b1;
                    ctl.squash_dec = 1'b1;
                    st_d.br_wait   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    wait_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.br_wait && !data_hit && (dec_cf == CF_COND || dec_cf == CF_REG)) |=> st_q.br_wait);

    // R8
    stall_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.br_wait && data_hit) |=> !st_q.br_wait);

    // R7
    resolve_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.br_wait && ex_resolved) |=> !st_q.br_wait);

    // R7
    resolve_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_resolved |-> st_q.br_wait);
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int AW       = 5,
    parameter int NSRC     = 2,
    parameter bit WB_SPLIT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC*AW-1:0]  dec_src,
    input  logic [NSRC-1:0]     dec_src_use,
    input  logic [1:0]          dec_cf,
    input  logic [3*AW-1:0]     lat_dst,
    input  logic [2:0]          lat_wen,
    input  logic                ex_resolved,
    output logic                hold_fetch,
    output logic                hold_dec,
    output logic                bubble_ex,
    output logic                squash_dec,
    output logic                redirect
);
    localparam int NSTG   = 3;
    localparam int WB_IDX = NSTG - 1;

    logic [NSTG-1:0] stage_hit;
    ctl_out_t        ctl;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        if (WB_SPLIT && s == WB_IDX) begin : g_split
            assign stage_hit[s] = 1'b0;
        end else begin : g_cmp
            hz_src_match #(.AW(AW), .NSRC(NSRC)) cmp_i (
                .srcs    (dec_src),
                .src_use (dec_src_use),
                .dst     (lat_dst[AW*s +: AW]),
                .wen     (lat_wen[s]),
                .hit     (stage_hit[s])
            );
        end
    end

    hz_cf_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_hit    (|stage_hit),
        .dec_cf      (cf_class_e'(dec_cf)),
        .ex_resolved (ex_resolved),
        .ctl         (ctl)
    );

    assign hold_fetch = ctl.hold_fetch;
    assign hold_dec   = ctl.hold_dec;
    assign bubble_ex  = ctl.bubble_ex;
    assign squash_dec = ctl.squash_dec;
    assign redirect   = ctl.redirect;

    // R1
    raw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stage_hit) && !squash_dec && !redirect) |-> (bubble_ex && hold_dec && hold_fetch));

    // R5
    redirect_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (squash_dec && !hold_fetch && !bubble_ex));
endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*AW-1:0] dec_src = '0;
    logic [1:0]      dec_src_use = '0;
    logic [1:0]      dec_cf = '0;
    logic [3*AW-1:0] lat_dst = '0;
    logic [2:0]      lat_wen = '0;
    logic            ex_resolved = 1'b0;
    logic hold_fetch, hold_dec, bubble_ex, squash_dec, redirect;

    int checks = 0;
    int errors = 0;
    bit m_wait = 0;

    always #4 clk = ~clk;

    pipe_hazard_unit dut_i (
        .clk(clk), .rst_n(rst_n), .dec_src(dec_src), .dec_src_use(dec_src_use),
        .dec_cf(dec_cf), .lat_dst(lat_dst), .lat_wen(lat_wen), .ex_resolved(ex_resolved),
        .hold_fetch(hold_fetch), .hold_dec(hold_dec), .bubble_ex(bubble_ex),
        .squash_dec(squash_dec), .redirect(redirect)
    );

    // expected {hold_fetch, hold_dec, bubble_ex, squash_dec, redirect}
    function automatic logic [4:0] model_out();
        bit raw = 0;
        for (int s = 0; s < 2; s++)
            for (int g = 0; g < 3; g++)
                if (dec_src_use[s] && lat_wen[g] && lat_dst[AW*g +: AW] != 0
                    && lat_dst[AW*g +: AW] == dec_src[AW*s +: AW]) raw = 1;
        if (m_wait) return ex_resolved ? 5'b00011 : 5'b10010;
        if (raw) return 5'b11100;
        if (dec_cf == 2) return 5'b00011;
        if (dec_cf == 1 || dec_cf == 3) return 5'b10010;
        return 5'b00000;
    endfunction

    task automatic step(input string tag);
        logic [4:0] exp_v, act_v;
        #2;
        exp_v = model_out();
        act_v = {hold_fetch, hold_dec, bubble_ex, squash_dec, redirect};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", tag, act_v, exp_v);
        end
        @(posedge clk);
        if (!rst_n) m_wait = 0;
        else if (m_wait) begin
            if (ex_resolved) m_wait = 0;
        end else if (exp_v == 5'b10010) m_wait = 1;
        @(negedge clk);
    endtask

    task automatic dec(input int s0, input bit u0, input int s1, input bit u1, input int cf);
        dec_src = {5'(s1), 5'(s0)};
        dec_src_use = {u1, u0};
        dec_cf = 2'(cf);
    endtask

    task automatic lat(input int e, input bit ew, input int m, input bit mw, input int w, input bit ww);
        lat_dst = {5'(w), 5'(m), 5'(e)};
        lat_wen = {ww, mw, ew};
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R9 in reset");
        step("R9 in reset");
        rst_n = 1'b1;
        step("R9 after reset");

        dec(5, 1, 0, 0, 0); lat(5, 1, 0, 0, 0, 0); step("R1 ex match");
        dec(3, 0, 7, 1, 0); lat(1, 1, 7, 1, 0, 0); step("R1 mem match");
        dec(4, 1, 6, 1, 0); lat(1, 1, 2, 1, 3, 1); step("R1 no match");
        dec(4, 1, 9, 1, 0); lat(0, 0, 0, 0, 9, 1); step("R2 wb match");
        dec(4, 1, 0, 0, 0); lat(4, 0, 4, 0, 4, 0); step("R3 wen low");
        dec(0, 1, 0, 1, 0); lat(0, 1, 0, 1, 0, 1); step("R3 reg zero");
        dec(8, 0, 8, 0, 0); lat(8, 1, 8, 1, 8, 1); step("R3 use low");

        dec(0, 0, 0, 0, 2); lat(0, 0, 0, 0, 0, 0); step("R5 direct jump");
        dec(0, 0, 0, 0, 0); step("R4 none class");
        dec(2, 1, 0, 0, 1); step("R6 cond in decode");
        dec(0, 0, 0, 0, 0); step("R7 wait unresolved");
        step("R7 wait unresolved");
        ex_resolved = 1; step("R7 resolved");
        ex_resolved = 0; step("R7 wait ended");

        dec(6, 1, 0, 0, 3); lat(6, 1, 0, 0, 0, 0); step("R8 indirect with hazard");
        lat(0, 0, 6, 1, 0, 0); step("R8 hazard in mem");
        lat(0, 0, 0, 0, 0, 0); step("R6 indirect released");
        dec(6, 1, 6, 1, 2); lat(6, 1, 6, 1, 6, 1); step("R10 decode ignored");
        ex_resolved = 1; step("R10 resolve with busy decode");
        ex_resolved = 0; step("R1 stall after wait");
        dec(0, 0, 0, 0, 0); lat(0, 0, 0, 0, 0, 0); step("R9 quiet");

        for (int n = 0; n < 400; n++) begin
            dec($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                $urandom_range(0, 3));
            lat($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                $urandom_range(0, 3), 1'($urandom));
            ex_resolved = m_wait ? 1'($urandom) : 1'b0;
            step("mixed sweep R1 R6 R7 R10");
        end
        ex_resolved = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule